// File: doc/BRIEF.md
# Multiply-Divide Unit with HI/LO Read Interlock

This block performs 32-bit signed and unsigned multiplies and divides for a scalar integer core and keeps the 64-bit outcome in a pair of result registers, HI and LO. The arithmetic result is written at the clock edge that accepts the command. The unit also models how long the operation would take on a sequential datapath. It loads a down-counter with a latency and holds off any HI or LO read until that counter has drained. Divides always cost 37 cycles. A multiply costs 7, 11 or 15 cycles, depending on how many leading bits of the first operand are redundant.

Commands arrive on a valid-only port. The unit has no back-pressure on commands: every cycle with `cmd_valid` high issues an operation. A new command replaces both the pending result and the remaining count. The read side works as a request with inverted ready. The core raises `rd_req` and selects HI or LO with `rd_sel`. It must hold the request while `rd_stall` is high, and it may consume `rd_data` in the first cycle where `rd_stall` is low. A read raised in the same cycle as an issue sees the state from before that issue. The `stall_off` input masks the stall output but leaves the arithmetic and the counter unchanged.

Top module: `muldiv_interlock`

## Requirements
- R1: Op code 2'b00 is a signed multiply. HI receives bits 63..32 and LO receives bits 31..0 of the 64-bit two's-complement product of `cmd_rs` and `cmd_rt`.
- R2: Op code 2'b01 is an unsigned multiply. It splits the unsigned 64-bit product into HI and LO in the same way.
- R3: Op code 2'b10 is a signed divide and 2'b11 is an unsigned divide. LO receives the quotient and HI the remainder. A signed quotient truncates toward zero, and the remainder takes the sign of the dividend.
- R4: When the divisor is zero, HI receives the dividend. LO receives 0xFFFFFFFF for an unsigned divide. For a signed divide, LO receives 1 if the dividend is negative and 0xFFFFFFFF otherwise.
- R5: A signed divide of 0x80000000 by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R6: After any divide, a held read stalls in exactly the 37 cycles that follow the issue cycle.
- R7: After an unsigned multiply, the stall length is 7 + 4*(2 - floor(lz/11)), where lz is the leading-zero count of `cmd_rs` with bit 0 forced to one. The result is 15, 11 or 7 cycles.
- R8: After a signed multiply, the same formula applies to the key (rs XOR (rs arithmetically shifted right by 21)) with bit 0 forced to one. Small negative operands therefore count as short.
- R9: `rd_stall` is high only while `rd_req` is high and cycles of the latency remain. Once the count is exhausted, a read completes at once. `rd_sel` = 1 returns HI and 0 returns LO.
- R10: While `stall_off` is high, `rd_stall` stays low and results are still written. The countdown keeps running, so clearing `stall_off` exposes whatever cycles remain.
- R11: A command issued while cycles remain restarts the count with the new operation's latency, and its result replaces the pending one.
- R12: After reset, HI and LO read as zero and no read stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall_off | input | 1 | Masks the read stall when high |
| cmd_valid | input | 1 | Issues an operation this cycle |
| cmd_op | input | 2 | Operation code (see R1 to R3) |
| cmd_rs | input | 32 | First operand or dividend |
| cmd_rt | input | 32 | Second operand or divisor |
| rd_req | input | 1 | HI/LO read request |
| rd_sel | input | 1 | 1 selects HI, 0 selects LO |
| rd_stall | output | 1 | Read must be held this cycle |
| rd_data | output | 32 | Selected result register |

## Verification
Results and the count are both registered at the issue edge. The first cycle after issue therefore already shows the new HI/LO values and the full count, and the bench holds a read from that cycle on. It counts the sampled stall cycles, which must equal the latency exactly. Data is compared in the first cycle whose stall is low. All samples are taken on the falling clock edge, after inputs have settled following the rising edge. When a read is raised one cycle later, or after a reissue, the expected count is reduced or restarted by that offset.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  parameter int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    OP_MULS = 2'b00,
    OP_MULU = 2'b01,
    OP_DIVS = 2'b10,
    OP_DIVU = 2'b11
  } md_op_e;

  // Count of zero bits above the most significant one.
  function automatic logic [5:0] lead_zeros(input logic [DATA_W-1:0] v);
    logic [5:0] n;
    logic       seen;
    n    = '0;
    seen = 1'b0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (!seen && !v[i]) n = n + 6'd1;
      else seen = 1'b1;
    end
    return n;
  endfunction
endpackage

// File: rtl/md_latency.sv
module md_latency
  import muldiv_pkg::*;
#(
  parameter int unsigned DIV_LAT   = 37,
  parameter int unsigned MUL_BASE  = 7,
  parameter int unsigned MUL_STEP  = 4,
  parameter int unsigned LZ_BAND   = 11,
  parameter int unsigned SGN_SHIFT = 21,
  parameter int unsigned CNT_W     = 6
) (
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] rs,
  output logic [CNT_W-1:0]  lat
);
  localparam int unsigned NBANDS = (DATA_W - 1) / LZ_BAND;

  logic [DATA_W-1:0] ext;
  logic [DATA_W-1:0] key;
  logic [5:0]        lz;
  int unsigned       band;

  always_comb begin
    ext = DATA_W'($signed(rs) >>> SGN_SHIFT);
    // op[0] = 1 selects the unsigned key
    key = (op[0] ? rs : (rs ^ ext)) | {{(DATA_W-1){1'b0}}, 1'b1};
    lz  = lead_zeros(key);
    band = 32'(lz) / LZ_BAND;
    if (op[1]) lat = CNT_W'(DIV_LAT);
    else       lat = CNT_W'(MUL_BASE + MUL_STEP * (NBANDS - band));
  end
endmodule

// File: rtl/md_arith.sv
module md_arith
  import muldiv_pkg::*;
(
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] rs,
  input  logic [DATA_W-1:0] rt,
  output logic [DATA_W-1:0] hi,
  output logic [DATA_W-1:0] lo
);
  localparam int unsigned PW = 2 * DATA_W;

  logic [PW-1:0]     prod;
  logic              sgn;
  logic [DATA_W-1:0] mag_a, mag_b, q_u, r_u;

  always_comb begin
    sgn   = (op == OP_MULS) || (op == OP_DIVS);
    prod  = {{DATA_W{sgn & rs[DATA_W-1]}}, rs} * {{DATA_W{sgn & rt[DATA_W-1]}}, rt};
    mag_a = (sgn && rs[DATA_W-1]) ? (~rs + 1'b1) : rs;
    mag_b = (sgn && rt[DATA_W-1]) ? (~rt + 1'b1) : rt;
    q_u   = '0;
    r_u   = '0;
    if (mag_b != '0) begin
      q_u = mag_a / mag_b;
      r_u = mag_a % mag_b;
    end
    hi = prod[PW-1:DATA_W];
    lo = prod[DATA_W-1:0];
    if (op[1]) begin
      if (rt == '0) begin
        hi = rs;
        lo = (sgn && rs[DATA_W-1]) ? {{(DATA_W-1){1'b0}}, 1'b1} : '1;
      end else begin
        // magnitude divide then sign fix; MIN / -1 wraps to MIN, remainder 0
        lo = (sgn && (rs[DATA_W-1] ^ rt[DATA_W-1])) ? (~q_u + 1'b1) : q_u;
        hi = (sgn && rs[DATA_W-1]) ? (~r_u + 1'b1) : r_u;
      end
    end
  end
endmodule

// File: rtl/md_countdown.sv
module md_countdown #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/muldiv_interlock.sv
module muldiv_interlock
  import muldiv_pkg::*;
#(
  parameter int unsigned DIV_LAT   = 37,
  parameter int unsigned MUL_BASE  = 7,
  parameter int unsigned MUL_STEP  = 4,
  parameter int unsigned LZ_BAND   = 11,
  parameter int unsigned SGN_SHIFT = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_off,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_rs,
  input  logic [DATA_W-1:0] cmd_rt,
  input  logic              rd_req,
  input  logic              rd_sel,
  output logic              rd_stall,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned CNT_W = $clog2(DIV_LAT + 1);

  logic [CNT_W-1:0]  lat;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] hi_d, lo_d, hi_q, lo_q;

  md_latency #(
    .DIV_LAT(DIV_LAT), .MUL_BASE(MUL_BASE), .MUL_STEP(MUL_STEP),
    .LZ_BAND(LZ_BAND), .SGN_SHIFT(SGN_SHIFT), .CNT_W(CNT_W)
  ) u_lat (
    .op(cmd_op), .rs(cmd_rs), .lat(lat)
  );

  md_arith u_arith (
    .op(cmd_op), .rs(cmd_rs), .rt(cmd_rt), .hi(hi_d), .lo(lo_d)
  );

  md_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cmd_valid), .load_val(lat), .cnt(cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (cmd_valid) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign rd_stall = rd_req && !stall_off && (cnt != '0);
  assign rd_data  = rd_sel ? hi_q : lo_q;
endmodule

// File: rtl/md_interlock_checker.sv
module md_interlock_checker #(
  parameter int unsigned DIV_LAT  = 37,
  parameter int unsigned MUL_BASE = 7,
  parameter int unsigned MUL_STEP = 4,
  parameter int unsigned CNT_W    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall_off,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic             rd_req,
  input logic             rd_stall,
  input logic [CNT_W-1:0] cnt,
  input logic [31:0]      hi_q,
  input logic [31:0]      lo_q
);
  // R9, R10: stall only with a request and with stalls enabled
  a_r9_stall_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stall |-> (rd_req && !stall_off));

  // R6: a divide loads the full divide latency
  a_r6_div_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op[1]) |=> (cnt == CNT_W'(DIV_LAT)));

  // R7, R8: a multiply loads one of the three banded latencies
  a_r7_mul_band: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_op[1]) |=> ((cnt == CNT_W'(MUL_BASE)) ||
                                   (cnt == CNT_W'(MUL_BASE + MUL_STEP)) ||
                                   (cnt == CNT_W'(MUL_BASE + 2 * MUL_STEP))));

  // R6: the count drains by one per idle cycle
  a_r6_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R9: an exhausted count stays exhausted without a command
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && cnt == '0) |=> (cnt == '0));

  // R11: results change only on issue
  a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

bind muldiv_interlock md_interlock_checker #(
  .DIV_LAT(DIV_LAT), .MUL_BASE(MUL_BASE), .MUL_STEP(MUL_STEP), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stall_off(stall_off), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .rd_req(rd_req), .rd_stall(rd_stall), .cnt(cnt),
  .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/tb_muldiv_interlock.sv
module tb_muldiv_interlock;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall_off = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [31:0] cmd_rs = '0, cmd_rt = '0;
  logic        rd_req = 1'b0;
  logic        rd_sel = 1'b0;
  logic        rd_stall;
  logic [31:0] rd_data;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  muldiv_interlock dut (
    .clk(clk), .rst_n(rst_n), .stall_off(stall_off), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_rs(cmd_rs), .cmd_rt(cmd_rt), .rd_req(rd_req),
    .rd_sel(rd_sel), .rd_stall(rd_stall), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input logic [1:0] op, input logic [31:0] rs);
    logic [31:0] key;
    int lz;
    if (op[1]) return 37;
    key = op[0] ? rs : (rs ^ 32'($signed(rs) >>> 21));
    key[0] = 1'b1;
    lz = 0;
    for (int i = 31; i >= 0; i--) begin
      if (key[i]) break;
      lz++;
    end
    return 7 + 4 * (2 - lz / 11);
  endfunction

  function automatic logic [63:0] exp_res(input logic [1:0] op, input logic [31:0] a,
                                          input logic [31:0] b);
    logic [63:0] p;
    logic [31:0] q, r;
    longint sa, sb;
    case (op)
      2'b00: p = 64'($signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b}));
      2'b01: p = {32'd0, a} * {32'd0, b};
      2'b11: begin
        if (b == 0) begin q = 32'hFFFF_FFFF; r = a; end
        else begin q = a / b; r = a % b; end
        p = {r, q};
      end
      default: begin
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        if (b == 0) begin q = a[31] ? 32'd1 : 32'hFFFF_FFFF; r = a; end
        else begin q = 32'(sa / sb); r = 32'(sa % sb); end
        p = {r, q};
      end
    endcase
    return p;
  endfunction

  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_rs = a; cmd_rt = b;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  // holds a read from now on; returns sampled stall cycles
  task automatic measure(output int n);
    n = 0;
    rd_req = 1'b1;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (!rd_stall) break;
      n++;
    end
  endtask

  task automatic read_check(input string req, input logic [63:0] e);
    rd_sel = 1'b1; #1; check(req, rd_data, e[63:32]);
    rd_sel = 1'b0; #1; check(req, rd_data, e[31:0]);
    rd_req = 1'b0;
  endtask

  task automatic run_vec(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    int n;
    string req;
    issue(op, a, b);
    measure(n);
    req = op[1] ? "R6" : (op[0] ? "R7" : "R8");
    check(req, 32'(n), 32'(exp_lat(op, a)));
    req = op[1] ? ((b == 0) ? "R4" : ((a == 32'h8000_0000 && b == '1 && !op[0]) ? "R5" : "R3"))
                : (op[0] ? "R2" : "R1");
    read_check(req, exp_res(op, a, b));
  endtask

  function automatic logic [31:0] corner(input int i);
    case (i)
      0: return 32'h0000_0000;  1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;  3: return 32'h8000_0000;
      4: return 32'h7FFF_FFFF;  5: return 32'h0000_0007;
      6: return 32'hFFFF_FFF9;  default: return 32'h0012_3456;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R12: reset state
    rd_req = 1'b1;
    @(negedge clk);
    check("R12", 32'(rd_stall), 0);
    rd_sel = 1'b1; #1 check("R12", rd_data, 0);
    rd_sel = 1'b0; #1 check("R12", rd_data, 0);
    rd_req = 1'b0;

    // R7: leading-zero band sweep over single-bit and zero operands
    for (int k = 0; k <= 32; k++) run_vec(2'b01, (k == 32) ? 32'd0 : (32'd1 << k), 32'h3);
    // R8: signed key sweep, positive and negative magnitudes
    for (int k = 0; k < 32; k++) begin
      run_vec(2'b00, 32'd1 << k, 32'hFFFF_FFFE);
      run_vec(2'b00, ~(32'd1 << k), 32'h5);
    end
    // R1..R5: all operations across the corner operand grid
    for (int op = 0; op < 4; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run_vec(2'(op), corner(i), corner(j));
    // R1..R3: pseudo-random operands
    for (int t = 0; t < 60; t++)
      for (int op = 0; op < 4; op++) begin
        logic [31:0] a, b;
        seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
        a = seed;
        seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
        b = (t % 3 == 0) ? (seed >> (t % 29)) : seed;
        run_vec(2'(op), a >> (t % 31), b);
      end

    // R9: no stall without a request, then the remaining cycles
    issue(2'b10, 32'd100, 32'd7);
    @(negedge clk);
    check("R9", 32'(rd_stall), 0);
    measure(n);
    check("R9", 32'(n), 36);
    @(negedge clk);
    check("R9", 32'(rd_stall), 0);
    read_check("R9", {32'd2, 32'd14});

    // R10: masked stall, counter continues
    stall_off = 1'b1;
    issue(2'b11, 32'd50, 32'd5);
    rd_req = 1'b1;
    @(negedge clk);
    check("R10", 32'(rd_stall), 0);
    rd_sel = 1'b0; #1 check("R10", rd_data, 32'd10);
    stall_off = 1'b0;
    measure(n);
    check("R10", 32'(n), 36);
    rd_req = 1'b0;

    // R11: reissue restarts the count and replaces the result
    issue(2'b10, 32'd9, 32'd2);
    repeat (5) @(posedge clk);
    #1;
    issue(2'b01, 32'd1, 32'd6);
    measure(n);
    check("R11", 32'(n), 7);
    read_check("R11", 64'd6);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule